// File: doc/BRIEF.md
# Stop-Mode Wake-Up Source Controller

This block governs how a small microcontroller leaves its low-power STOP state. An 8-bit control register, written over a plain write-enable register bus, picks one wake source from the port pins through a 3-bit code and sets the pin level that counts as a wake. The code can name a single pin or a NOR of a group of port-2 pins. Port-2 pins that are configured as outputs take no part in the wake logic. A separate wake request from a second recovery register and a watchdog timeout can also end STOP.

On recovery the block sends a one-cycle wake pulse and clears the clock divide-by-16 enable. It then either holds the core in reset for a programmable number of cycles or, in fast-wake mode, releases it at once. In fast-wake mode a pin source is accepted only after it has stayed active for several consecutive cycles. A read-only flag in the register records whether the last start was cold or warm.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After power-on reset (`rstN` low) the register reads 0x20 (bit 5 set, all other bits 0), and `sleeping`, `wakeOut`, `resetHold` and `clkDiv16En` are all 0.
- R2: A write stores data bits 6..2 and bit 0. Bit 7 and bit 1 are not writable, and bit 1 always reads 0. `clkDiv16En` follows register bit 0.
- R3: A `stopEntry` strobe while awake sets register bit 7 (warm) and sets `sleeping`. A `wdtTimeout` while awake clears bit 7 (cold). A recovery from STOP leaves bit 7 at 1.
- R4: Register bits 4..2 select the source. 010, 011 and 100 pick `port3In[0]`, `port3In[1]` and `port3In[2]`. 101 picks `port2In[7]`. Codes 000 and 001 never wake the block from a pin. Pins pass through a two-flop synchronizer.
- R5: Code 110 uses the NOR of `port2In[3:0]` and code 111 uses the NOR of `port2In[7:0]`. Within the group, any pin whose `port2IsOut` bit is 1 is treated as 0.
- R6: Register bit 6 sets the wake level of the selected source: 1 means a high level wakes, 0 means a low level wakes.
- R7: With code 101, the source never wakes the block while `port2IsOut[7]` is 1.
- R8: With register bit 5 at 0 (fast wake), a pin source wakes the block only after FAST_CYC consecutive synchronized active cycles, and `resetHold` stays 0. A shorter pulse does not wake it.
- R9: With register bit 5 at 1, `resetHold` is 1 for exactly DELAY_CYC cycles, starting in the cycle of the wake pulse.
- R10: While sleeping, `altWakeReq` or `wdtTimeout` held for one cycle wakes the block at the next clock edge, whatever the source code.
- R11: A recovery clears register bit 0, and this overrides a write of bit 0 = 1 in the same cycle.
- R12: `wakeOut` is a one-cycle pulse that occurs only on leaving STOP, in the same cycle that `sleeping` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read value |
| stopEntry | input | 1 | Strobe: core enters STOP |
| wdtTimeout | input | 1 | Watchdog timeout strobe |
| altWakeReq | input | 1 | Wake request from the second recovery register |
| port3In | input | 3 | Port-3 input pins usable as wake sources |
| port2In | input | 8 | Port-2 pins |
| port2IsOut | input | 8 | 1 = port-2 pin configured as an output |
| sleeping | output | 1 | Block is in STOP |
| wakeOut | output | 1 | One-cycle recovery pulse |
| resetHold | output | 1 | Post-wake reset hold |
| clkDiv16En | output | 1 | Enable for the clock divide-by-16 prescaler |

## Verification
A recovery and a register write can land in the same cycle, and both act on the divide-by-16 enable bit. The bench provokes this by putting the block to sleep and then, in one cycle, asserting `altWakeReq` together with a write that sets bit 0. It then expects the wake pulse with bit 0 read back as 0 and the other written fields kept. A second collision comes from a watchdog timeout during STOP: it must wake the block and must not clear the warm flag, which it would clear if it arrived while the block was awake.

// File: rtl/swk_pkg.sv
package swk_pkg;

  // Register bit positions (part of the programmer-visible behaviour)
  localparam int BIT_DIV   = 0;
  localparam int BIT_SRCLO = 2;
  localparam int BIT_SRCHI = 4;
  localparam int BIT_SLOW  = 5;
  localparam int BIT_POL   = 6;
  localparam int BIT_WARM  = 7;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'b000,
    SRC_RSVD   = 3'b001,
    SRC_P3A    = 3'b010,
    SRC_P3B    = 3'b011,
    SRC_P3C    = 3'b100,
    SRC_P2TOP  = 3'b101,
    SRC_NORLO  = 3'b110,
    SRC_NORALL = 3'b111
  } srcSel_t;

  typedef struct packed {
    logic wrCtrl;
    logic setWarm;
    logic clrWarm;
    logic wakeNow;
  } swkStrobe_t;

endpackage

// File: rtl/swk_datapath.sv
module swk_datapath
  import swk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int P3_W        = 3,
  parameter int P2_W        = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  swkStrobe_t      strobe,
  input  logic [7:0]      wrData,
  input  logic [P3_W-1:0] port3In,
  input  logic [P2_W-1:0] port2In,
  input  logic [P2_W-1:0] port2IsOut,
  output logic [7:0]      ctrlReg,
  output logic            srcActive
);

  localparam int RAW_W  = P3_W + P2_W;
  localparam int LO_W   = P2_W / 2;

  logic [RAW_W-1:0] syncQ [SYNC_STAGES];
  logic [P3_W-1:0]  p3Sync;
  logic [P2_W-1:0]  p2Sync;
  logic [P2_W-1:0]  p2Eff;
  logic             srcLevel;
  logic             srcValid;
  srcSel_t          srcSel;

  // Multi-stage synchronizer on all pin inputs
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= '0;
          else       syncQ[gi] <= {port2In, port3In};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= '0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign p3Sync = syncQ[SYNC_STAGES-1][P3_W-1:0];
  assign p2Sync = syncQ[SYNC_STAGES-1][RAW_W-1:P3_W];

  // Output-configured pins are forced to the inactive level (0)
  assign p2Eff  = p2Sync & ~port2IsOut;
  assign srcSel = srcSel_t'(ctrlReg[BIT_SRCHI:BIT_SRCLO]);

  always_comb begin
    srcLevel = 1'b0;
    srcValid = 1'b0;
    unique case (srcSel)
      SRC_P3A:    begin srcValid = 1'b1; srcLevel = p3Sync[0]; end
      SRC_P3B:    begin srcValid = 1'b1; srcLevel = p3Sync[1]; end
      SRC_P3C:    begin srcValid = 1'b1; srcLevel = p3Sync[2]; end
      SRC_P2TOP:  begin
        srcValid = ~port2IsOut[P2_W-1];
        srcLevel = p2Sync[P2_W-1];
      end
      SRC_NORLO:  begin srcValid = 1'b1; srcLevel = ~|p2Eff[LO_W-1:0]; end
      SRC_NORALL: begin srcValid = 1'b1; srcLevel = ~|p2Eff; end
      default:    begin srcValid = 1'b0; srcLevel = 1'b0; end
    endcase
  end

  assign srcActive = srcValid && (srcLevel == ctrlReg[BIT_POL]);

  // Control register; bit 1 is not implemented and stays 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
    end else begin
      if (strobe.wrCtrl) begin
        ctrlReg[BIT_POL:BIT_SRCLO] <= wrData[BIT_POL:BIT_SRCLO];
        ctrlReg[BIT_DIV]           <= wrData[BIT_DIV];
      end
      if (strobe.setWarm) ctrlReg[BIT_WARM] <= 1'b1;
      if (strobe.clrWarm) ctrlReg[BIT_WARM] <= 1'b0;
      if (strobe.wakeNow) ctrlReg[BIT_DIV]  <= 1'b0;
    end
  end

endmodule

// File: rtl/swk_control.sv
module swk_control
  import swk_pkg::*;
#(
  parameter int FAST_CYC  = 5,
  parameter int DELAY_CYC = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       stopEntry,
  input  logic       wdtTimeout,
  input  logic       altWakeReq,
  input  logic       srcActive,
  input  logic       slowWake,
  output swkStrobe_t strobe,
  output logic       sleeping,
  output logic       wakeOut,
  output logic       resetHold
);

  localparam int QW = $clog2(FAST_CYC + 1);
  localparam int DW = $clog2(DELAY_CYC + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(FAST_CYC - 1);
  localparam logic [QW-1:0] Q_MAX  = QW'(FAST_CYC);
  localparam logic [DW-1:0] D_LOAD = DW'(DELAY_CYC);

  logic [QW-1:0] qualCnt;
  logic [DW-1:0] holdCnt;
  logic          srcWake;
  logic          wakeNow;

  // Pin source qualifies at once in delayed mode, after FAST_CYC cycles in fast mode
  assign srcWake = srcActive && (slowWake || (qualCnt >= Q_LAST));
  assign wakeNow = sleeping && (srcWake || altWakeReq || wdtTimeout);

  always_comb begin
    strobe         = '0;
    strobe.wrCtrl  = regWrEn;
    strobe.setWarm = stopEntry && !sleeping;
    strobe.clrWarm = wdtTimeout && !sleeping && !stopEntry;
    strobe.wakeNow = wakeNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleeping <= 1'b0;
      wakeOut  <= 1'b0;
      qualCnt  <= '0;
      holdCnt  <= '0;
    end else begin
      wakeOut <= wakeNow;
      if (wakeNow)        sleeping <= 1'b0;
      else if (stopEntry) sleeping <= 1'b1;

      if (!sleeping || !srcActive || wakeNow) qualCnt <= '0;
      else if (qualCnt != Q_MAX)              qualCnt <= qualCnt + 1'b1;

      if (wakeNow && slowWake) holdCnt <= D_LOAD;
      else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
    end
  end

  assign resetHold = (holdCnt != '0);

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int FAST_CYC    = 5,
  parameter int DELAY_CYC   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       stopEntry,
  input  logic       wdtTimeout,
  input  logic       altWakeReq,
  input  logic [2:0] port3In,
  input  logic [7:0] port2In,
  input  logic [7:0] port2IsOut,
  output logic       sleeping,
  output logic       wakeOut,
  output logic       resetHold,
  output logic       clkDiv16En
);

  swkStrobe_t strobe;
  logic [7:0] ctrlReg;
  logic       srcActive;

  swk_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .P3_W(3),
    .P2_W(8)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .port3In   (port3In),
    .port2In   (port2In),
    .port2IsOut(port2IsOut),
    .ctrlReg   (ctrlReg),
    .srcActive (srcActive)
  );

  swk_control #(
    .FAST_CYC (FAST_CYC),
    .DELAY_CYC(DELAY_CYC)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .stopEntry (stopEntry),
    .wdtTimeout(wdtTimeout),
    .altWakeReq(altWakeReq),
    .srcActive (srcActive),
    .slowWake  (ctrlReg[BIT_SLOW]),
    .strobe    (strobe),
    .sleeping  (sleeping),
    .wakeOut   (wakeOut),
    .resetHold (resetHold)
  );

  assign regRdData  = ctrlReg;
  assign clkDiv16En = ctrlReg[BIT_DIV];

endmodule

// File: rtl/swk_checker.sv
module swk_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdData,
  input logic       altWakeReq,
  input logic       sleeping,
  input logic       wakeOut,
  input logic       resetHold
);

  // R11: the recovery cycle always shows the divider enable cleared
  p_div_cleared_r11: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (regRdData[0] == 1'b0));

  // R12: wake pulse lasts one cycle
  p_wake_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |=> !wakeOut);

  // R12: wake pulse only when leaving STOP
  p_wake_from_stop_r12: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> ($past(sleeping) && !sleeping));

  // R9: reset hold only starts together with a wake pulse
  p_hold_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetHold) |-> wakeOut);

  // R3: entering STOP marks a warm start
  p_stop_warm_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleeping) |-> regRdData[7]);

  // R10: second-register request ends STOP at the next edge
  p_alt_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && altWakeReq) |=> (wakeOut && !sleeping));

  // R2: bit 1 is never set
  p_bit1_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[1] == 1'b0);

endmodule

bind stop_wake_ctrl swk_checker u_swk_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regRdData (regRdData),
  .altWakeReq(altWakeReq),
  .sleeping  (sleeping),
  .wakeOut   (wakeOut),
  .resetHold (resetHold)
);

// File: tb/stop_wake_ctrl_test.sv
`timescale 1ns/1ps
module stop_wake_ctrl_test;

  localparam int FAST_CYC  = 5;
  localparam int DELAY_CYC = 32;
  localparam int NVEC      = 15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       stopEntry = 1'b0;
  logic       wdtTimeout = 1'b0;
  logic       altWakeReq = 1'b0;
  logic [2:0] port3In = '0;
  logic [7:0] port2In = '0;
  logic [7:0] port2IsOut = '0;
  logic       sleeping, wakeOut, resetHold, clkDiv16En;

  int testCnt = 0;
  int failCnt = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  stop_wake_ctrl #(.FAST_CYC(FAST_CYC), .DELAY_CYC(DELAY_CYC)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .stopEntry(stopEntry), .wdtTimeout(wdtTimeout),
    .altWakeReq(altWakeReq), .port3In(port3In), .port2In(port2In),
    .port2IsOut(port2IsOut), .sleeping(sleeping), .wakeOut(wakeOut),
    .resetHold(resetHold), .clkDiv16En(clkDiv16En)
  );

  // {expectWake, pol, code[2:0], p3[2:0], p2[7:0], p2IsOut[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 3'b010, 3'b001, 8'h00, 8'h00},  // R4 P3 pin 0
    {1'b0, 1'b1, 3'b010, 3'b110, 8'h00, 8'h00},  // R4 other pins only
    {1'b1, 1'b1, 3'b011, 3'b010, 8'h00, 8'h00},  // R4 P3 pin 1
    {1'b1, 1'b1, 3'b100, 3'b100, 8'h00, 8'h00},  // R4 P3 pin 2
    {1'b1, 1'b0, 3'b100, 3'b011, 8'h00, 8'h00},  // R6 low level wakes
    {1'b1, 1'b1, 3'b101, 3'b000, 8'h80, 8'h00},  // R4 P2 pin 7
    {1'b0, 1'b1, 3'b101, 3'b000, 8'h80, 8'h80},  // R7 pin 7 is output
    {1'b1, 1'b1, 3'b110, 3'b000, 8'hF0, 8'h00},  // R5 low nibble NOR
    {1'b0, 1'b1, 3'b110, 3'b000, 8'h01, 8'h00},  // R5 one pin high
    {1'b1, 1'b1, 3'b110, 3'b000, 8'h01, 8'h01},  // R5 high pin masked
    {1'b0, 1'b1, 3'b111, 3'b000, 8'hF0, 8'h00},  // R5 full NOR blocked
    {1'b1, 1'b1, 3'b111, 3'b000, 8'h00, 8'h00},  // R5 full NOR
    {1'b1, 1'b0, 3'b111, 3'b000, 8'h10, 8'h00},  // R6 NOR low level
    {1'b0, 1'b1, 3'b000, 3'b111, 8'hFF, 8'h00},  // R4 code 000
    {1'b0, 1'b1, 3'b001, 3'b111, 8'hFF, 8'h00}   // R4 code 001
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic enterStop();
    @(negedge clk); stopEntry = 1'b1;
    @(negedge clk); stopEntry = 1'b0;
  endtask

  task automatic altPulse();
    @(negedge clk); altWakeReq = 1'b1;
    @(negedge clk); altWakeReq = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int n;
    logic [23:0] v;
    // R1 reset state
    cyc(3);
    check(regRdData == 8'h20, "R1 reg", regRdData, 8'h20);
    check({sleeping, wakeOut, resetHold, clkDiv16En} == 4'b0, "R1 outputs",
          {sleeping, wakeOut, resetHold, clkDiv16En}, 0);
    @(negedge clk); rstN = 1'b1;
    cyc(2);

    // R2 writable bits
    regWrite(8'hFF);
    check(regRdData == 8'h7D, "R2 write mask", regRdData, 8'h7D);
    check(clkDiv16En == 1'b1, "R2 div enable", clkDiv16En, 1);
    regWrite(8'h20);

    // Vector table: delayed-wake mode (bit 5 = 1)
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      @(negedge clk);
      port3In = v[18:16]; port2In = v[15:8]; port2IsOut = v[7:0];
      regWrite({1'b0, v[22], 1'b1, v[21:19], 2'b00});
      cyc(4);
      enterStop();
      cyc(8);
      check(sleeping == !v[23], $sformatf("R4/R5/R6/R7 vector %0d sleeping", k),
            sleeping, !v[23]);
      if (!v[23]) altPulse();
      cyc(DELAY_CYC + 4);
      port3In = '0; port2In = '0; port2IsOut = '0;
    end

    // R3 warm flag after recovery, cleared by watchdog while awake
    check(regRdData[7] == 1'b1, "R3 warm after recovery", regRdData[7], 1);
    @(negedge clk); wdtTimeout = 1'b1;
    @(negedge clk); wdtTimeout = 1'b0;
    check(regRdData[7] == 1'b0, "R3 cold after awake watchdog", regRdData[7], 0);
    check(sleeping == 1'b0, "R3 awake watchdog no stop", sleeping, 0);

    // R10/R11/R12 collision: wake and write of bit 0 in one cycle
    regWrite(8'h20);
    enterStop();
    check(sleeping == 1'b1 && regRdData[7] == 1'b1, "R3 stop entry",
          {sleeping, regRdData[7]}, 2'b11);
    cyc(2);
    check(wakeOut == 1'b0, "R12 no pulse while asleep", wakeOut, 0);
    @(negedge clk); altWakeReq = 1'b1; regWrEn = 1'b1; regWrData = 8'h49;
    @(negedge clk); altWakeReq = 1'b0; regWrEn = 1'b0;
    check(wakeOut == 1'b1 && sleeping == 1'b0, "R10 alt wake",
          {wakeOut, sleeping}, 2'b10);
    check(regRdData == 8'hC8, "R11 wake clears div over write", regRdData, 8'hC8);
    // R9 hold length, counted from the pulse cycle
    n = 0;
    while (resetHold && n < 1000) begin n++; @(negedge clk); end
    check(n == DELAY_CYC, "R9 hold length", n, DELAY_CYC);
    cyc(1);
    check(wakeOut == 1'b0, "R12 single pulse", wakeOut, 0);

    // R10 watchdog during STOP wakes and keeps warm flag
    regWrite(8'h20);
    enterStop();
    @(negedge clk); wdtTimeout = 1'b1;
    @(negedge clk); wdtTimeout = 1'b0;
    check(sleeping == 1'b0 && wakeOut == 1'b1, "R10 watchdog wake",
          {sleeping, wakeOut}, 2'b01);
    check(regRdData[7] == 1'b1, "R3 warm kept on stop watchdog", regRdData[7], 1);
    cyc(DELAY_CYC + 4);

    // R8 fast wake: short pulse rejected, long hold accepted, no hold
    regWrite({1'b0, 1'b1, 1'b0, 3'b010, 2'b00});
    cyc(4);
    enterStop();
    @(negedge clk); port3In = 3'b001;
    cyc(FAST_CYC - 2);
    port3In = 3'b000;
    cyc(8);
    check(sleeping == 1'b1, "R8 short pulse rejected", sleeping, 1);
    port3In = 3'b001;
    n = 0;
    while (sleeping && n < 50) begin n++; @(negedge clk); end
    check(sleeping == 1'b0, "R8 long hold wakes", sleeping, 0);
    check(n >= FAST_CYC, "R8 qualify time", n, FAST_CYC);
    check(resetHold == 1'b0, "R8 no reset hold", resetHold, 0);
    port3In = 3'b000;
    cyc(4);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule